// File: doc/BRIEF.md
# Buzzer Tone Sequencer

This block decides when a clock's buzzer sounds and which of two pitches it plays. A free-running divider turns the system clock into a fast square wave, 1000 Hz at the default 50 MHz clock. A second register toggles on every rising edge of that wave to give the slow tone at half the pitch. Each cycle the block compares the live time against the alarm setting, looks for the last ten seconds of each hour, and checks a warning request from a countdown timer. It then sends either one of the tones or a constant low level to a single buzzer pin.

The pitch changes with the parity of the live seconds value. Because the seconds advance once a second, the tone alternates every second without a separate tone timer. The live and alarm times arrive as packed BCD bytes, with the tens digit in bits [7:4] and the units digit in bits [3:0]. The tone sources sit on a register boundary. The path from the time inputs to the buzzer pin is combinational.

Top module: `buzz_sequencer`

## Requirements
- R1: The fast tone is a square wave with a period of DIV_FAST = CLK_HZ / TONE_HZ cycles and a 50% duty cycle. It is low for the first DIV_FAST/2 cycles after reset is released, and it changes level every DIV_FAST/2 cycles after that.
- R2: The slow tone changes level only on a rising edge of the fast tone, and on every such edge, so its period is 2*DIV_FAST cycles. It is low for the first DIV_FAST/2 cycles after reset and then turns high.
- R3: While rst_n is low at a rising clock edge, the divider and both tones are cleared, so buzz_o is low in the cycle that follows.
- R4: The alarm condition holds when alarm_en_n_i is 0 and live_hour_i equals alarm_hour_i and live_min_i equals alarm_min_i. The seconds take no part in this match, so the alarm lasts for the whole matching minute.
- R5: While the alarm condition holds, buzz_o follows the fast tone when bit 0 of live_sec_i is 0 (even seconds) and the slow tone when that bit is 1.
- R6: The hourly chime condition holds when live_min_i is 8'h59 and the seconds tens digit live_sec_i[7:4] is 5. While it holds, buzz_o follows the fast tone on odd seconds and the slow tone on even seconds.
- R7: When timer_warn_i is 1, buzz_o follows the fast tone on odd seconds and the slow tone on even seconds.
- R8: The alarm has priority over the chime and the timer warning. When the alarm condition holds, the R5 pitch mapping applies even if another condition also holds.
- R9: When none of the three conditions holds, buzz_o is 0.
- R10: When alarm_en_n_i is 1, a matching alarm time has no effect on buzz_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (CLK_HZ) |
| rst_n | input | 1 | Synchronous reset, active low |
| live_hour_i | input | 8 | Live hours, BCD |
| live_min_i | input | 8 | Live minutes, BCD |
| live_sec_i | input | 8 | Live seconds, BCD |
| alarm_hour_i | input | 8 | Alarm hours, BCD |
| alarm_min_i | input | 8 | Alarm minutes, BCD |
| alarm_en_n_i | input | 1 | Alarm enable, active low |
| timer_warn_i | input | 1 | Countdown timer warning request |
| buzz_o | output | 1 | Buzzer drive |

## Verification
A divider count that is off by one, or a wrong wrap point, shifts the phase of every later edge on buzz_o. This is visible within half a tone period of reset release, as soon as any condition selects a tone. A slow-tone register that toggles on the wrong edge shows up as a phase error against the rising edges of the fast tone within one fast period. A wrong priority or parity decode in the event logic has no hidden state. It is visible in the same cycle that the offending time values are applied, so a sweep over all seconds values, the minutes around the hour, and each combination of the enable and warning inputs exposes it at once.

// File: rtl/buzz_pkg.sv
// Shared types for the buzzer tone sequencer.
// Assumes BCD time bytes: tens digit in [7:4], units digit in [3:0].
package buzz_pkg;

    typedef struct packed {
        logic [7:0] hh;
        logic [7:0] mm;
    } hm_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_ALARM = 2'd1,
        SRC_CHIME = 2'd2,
        SRC_TIMER = 2'd3
    } src_e;

    localparam logic [7:0] CHIME_MIN      = 8'h59;
    localparam logic [3:0] CHIME_SEC_TENS = 4'h5;

endpackage

// File: rtl/buzz_tone_gen.sv
// Tone generator: divides the clock by DIV_FAST to give a 50% duty square
// wave, and toggles a second register on every rising edge of that wave to
// give a tone at half the pitch.
// Assumes DIV_FAST is even and at least 2.
module buzz_tone_gen #(
    parameter int DIV_FAST = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tone_fast_o,
    output logic tone_slow_o
);
    localparam int HALF = DIV_FAST / 2;
    localparam int CW   = (DIV_FAST > 2) ? $clog2(DIV_FAST) : 1;

    logic [CW-1:0] div_q;
    logic          at_half;
    logic          at_end;
    logic          fast_rise;

    assign at_half   = (div_q == CW'(HALF - 1));
    assign at_end    = (div_q == CW'(DIV_FAST - 1));
    assign fast_rise = (at_half || at_end) && !tone_fast_o;

    // Purpose: free-running divider count, wrapping after DIV_FAST cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (at_end) div_q <= '0;
        else             div_q <= div_q + 1'b1;
    end

    // Purpose: fast tone changes level at the half point and at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                  tone_fast_o <= 1'b0;
        else if (at_half || at_end)  tone_fast_o <= !tone_fast_o;
    end

    // Purpose: slow tone toggles on each rising edge of the fast tone.
    always_ff @(posedge clk) begin
        if (!rst_n)         tone_slow_o <= 1'b0;
        else if (fast_rise) tone_slow_o <= !tone_slow_o;
    end

endmodule

// File: rtl/buzz_event_detect.sv
// Event detector: decides which condition drives the buzzer and whether the
// fast or the slow tone is wanted. Priority: alarm, then chime, then timer.
// Assumes BCD inputs; the parity of the seconds is bit 0 of the units digit.
module buzz_event_detect
    import buzz_pkg::*;
(
    input  hm_t        live_hm_i,
    input  logic [7:0] live_sec_i,
    input  hm_t        alarm_hm_i,
    input  logic       alarm_en_n_i,
    input  logic       timer_warn_i,
    output src_e       src_o,
    output logic       pick_fast_o
);
    logic alarm_hit;
    logic chime_hit;
    logic sec_odd;

    assign alarm_hit = !alarm_en_n_i && (live_hm_i == alarm_hm_i);
    assign chime_hit = (live_hm_i.mm == CHIME_MIN) && (live_sec_i[7:4] == CHIME_SEC_TENS);
    assign sec_odd   = live_sec_i[0];

    // Purpose: priority choice of source and of pitch parity.
    always_comb begin
        src_o       = SRC_NONE;
        pick_fast_o = 1'b0;
        if (alarm_hit) begin
            src_o       = SRC_ALARM;
            pick_fast_o = !sec_odd;
        end else if (chime_hit) begin
            src_o       = SRC_CHIME;
            pick_fast_o = sec_odd;
        end else if (timer_warn_i) begin
            src_o       = SRC_TIMER;
            pick_fast_o = sec_odd;
        end
    end

endmodule

// File: rtl/buzz_sequencer.sv
// Top level of the buzzer tone sequencer: tone generator plus event
// detector, with a final mux onto the buzzer pin.
// Assumes CLK_HZ / TONE_HZ is an even whole number.
module buzz_sequencer
    import buzz_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int TONE_HZ = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] live_hour_i,
    input  logic [7:0] live_min_i,
    input  logic [7:0] live_sec_i,
    input  logic [7:0] alarm_hour_i,
    input  logic [7:0] alarm_min_i,
    input  logic       alarm_en_n_i,
    input  logic       timer_warn_i,
    output logic       buzz_o
);
    localparam int DIV_FAST = CLK_HZ / TONE_HZ;

    logic tone_fast;
    logic tone_slow;
    src_e src;
    logic pick_fast;
    hm_t  live_hm;
    hm_t  alarm_hm;

    assign live_hm  = '{hh: live_hour_i,  mm: live_min_i};
    assign alarm_hm = '{hh: alarm_hour_i, mm: alarm_min_i};

    buzz_tone_gen #(.DIV_FAST(DIV_FAST)) tone_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tone_fast_o (tone_fast),
        .tone_slow_o (tone_slow)
    );

    buzz_event_detect evt_i (
        .live_hm_i    (live_hm),
        .live_sec_i   (live_sec_i),
        .alarm_hm_i   (alarm_hm),
        .alarm_en_n_i (alarm_en_n_i),
        .timer_warn_i (timer_warn_i),
        .src_o        (src),
        .pick_fast_o  (pick_fast)
    );

    // Purpose: drive the buzzer from the chosen tone, or hold it low.
    always_comb begin
        if (src == SRC_NONE) buzz_o = 1'b0;
        else                 buzz_o = pick_fast ? tone_fast : tone_slow;
    end

endmodule

// File: rtl/buzz_sequencer_chk.sv
// Checker for the buzzer tone sequencer, attached by bind. It decodes the
// conditions from the ports on its own and watches the two tone registers.
module buzz_sequencer_chk #(
    parameter int CLK_HZ  = 50_000_000,
    parameter int TONE_HZ = 1000
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] live_hour_i,
    input logic [7:0] live_min_i,
    input logic [7:0] live_sec_i,
    input logic [7:0] alarm_hour_i,
    input logic [7:0] alarm_min_i,
    input logic       alarm_en_n_i,
    input logic       timer_warn_i,
    input logic       tone_fast,
    input logic       tone_slow,
    input logic       buzz_o
);
    localparam int HALF = (CLK_HZ / TONE_HZ) / 2;
    localparam int RW   = $clog2(HALF + 2) + 1;

    logic          c_alarm;
    logic          c_chime;
    logic [RW-1:0] run_q;
    logic          last_q;

    assign c_alarm = (alarm_en_n_i == 1'b0) && (live_hour_i == alarm_hour_i) && (live_min_i == alarm_min_i);
    assign c_chime = (live_min_i == 8'h59) && (live_sec_i >= 8'h50) && (live_sec_i <= 8'h59);

    // Purpose: count how many cycles the fast tone has kept its level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            last_q <= 1'b0;
        end else begin
            run_q  <= (tone_fast != last_q) ? RW'(1) : run_q + 1'b1;
            last_q <= tone_fast;
        end
    end

    // R1: each level of the fast tone lasts exactly half a period
    assert_fast_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_fast != last_q) |-> (run_q == RW'(HALF)));

    // R2: the slow tone moves only on a rising edge of the fast tone
    assert_slow_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tone_slow) |-> $rose(tone_fast));

    // R3: both tones are low when reset has just been released
    assert_reset_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!tone_fast && !tone_slow && !buzz_o));

    // R5: alarm on an even second plays the fast tone
    assert_alarm_pitch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_alarm && !live_sec_i[0]) |-> (buzz_o == tone_fast));

    // R6: chime on an odd second without alarm plays the fast tone
    assert_chime_pitch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_alarm && c_chime && live_sec_i[0]) |-> (buzz_o == tone_fast));

    // R9: silence when no condition holds
    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_alarm && !c_chime && !timer_warn_i) |-> !buzz_o);

endmodule

bind buzz_sequencer buzz_sequencer_chk #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .live_hour_i  (live_hour_i),
    .live_min_i   (live_min_i),
    .live_sec_i   (live_sec_i),
    .alarm_hour_i (alarm_hour_i),
    .alarm_min_i  (alarm_min_i),
    .alarm_en_n_i (alarm_en_n_i),
    .timer_warn_i (timer_warn_i),
    .tone_fast    (tone_fast),
    .tone_slow    (tone_slow),
    .buzz_o       (buzz_o)
);

// File: tb/buzz_sequencer_tb_top.sv
// Bench for the buzzer tone sequencer: directed divider and reset runs, then
// a sweep over seconds, minutes, alarm settings, enable and warning.
module buzz_sequencer_tb_top;
    localparam int CLK_HZ  = 8000;
    localparam int TONE_HZ = 1000;
    localparam int DIV     = CLK_HZ / TONE_HZ;
    localparam int HALF    = DIV / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] live_hour = 8'h12;
    logic [7:0] live_min = 8'h00;
    logic [7:0] live_sec = 8'h00;
    logic [7:0] alarm_hour = 8'h07;
    logic [7:0] alarm_min = 8'h30;
    logic       alarm_en_n = 1'b1;
    logic       timer_warn = 1'b0;
    logic       buzz;

    int  kcnt = 0;
    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #10 clk = !clk;

    // Edges counted since reset was released.
    always @(posedge clk) begin
        if (!rst_n) kcnt <= 0;
        else        kcnt <= kcnt + 1;
    end

    buzz_sequencer #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .live_hour_i  (live_hour),
        .live_min_i   (live_min),
        .live_sec_i   (live_sec),
        .alarm_hour_i (alarm_hour),
        .alarm_min_i  (alarm_min),
        .alarm_en_n_i (alarm_en_n),
        .timer_warn_i (timer_warn),
        .buzz_o       (buzz)
    );

    function automatic logic fast_at(input int k);
        return logic'((k / HALF) % 2);
    endfunction

    function automatic logic slow_at(input int k);
        return logic'(((k + HALF) / DIV) % 2);
    endfunction

    function automatic int bcd2int(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    // Condition decode from the requirements: 1 alarm, 2 chime, 3 timer, 0 none.
    function automatic int cond_now();
        if (!alarm_en_n && live_hour == alarm_hour && live_min == alarm_min) return 1;
        if (live_min == 8'h59 && bcd2int(live_sec) >= 50) return 2;
        if (timer_warn) return 3;
        return 0;
    endfunction

    function automatic logic model_buzz(input int k);
        int  c   = cond_now();
        bit  odd = (bcd2int(live_sec) % 2) == 1;
        if (c == 1) return odd ? slow_at(k) : fast_at(k);
        if (c != 0) return odd ? fast_at(k) : slow_at(k);
        return 1'b0;
    endfunction

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (buzz !== exp) begin
            n_fail++;
            $display("FAIL %s: buzz=%b expected %b (k=%0d h=%h m=%h s=%h ah=%h am=%h en_n=%b warn=%b)",
                     req, buzz, exp, kcnt, live_hour, live_min, live_sec,
                     alarm_hour, alarm_min, alarm_en_n, timer_warn);
        end
    endtask

    function automatic string sweep_tag();
        int c = cond_now();
        if (c == 1) begin
            if (live_min == 8'h59 && bcd2int(live_sec) >= 50) return "R8";
            if (timer_warn) return "R8";
            return "R5";
        end
        if (c == 2) return "R6";
        if (c == 3) return "R7";
        if (!alarm_en_n) return "R4";
        if (live_hour == alarm_hour && live_min == alarm_min) return "R10";
        return "R9";
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        // R3: during reset the buzzer is low even with a request active
        timer_warn = 1'b1;
        live_sec   = 8'h01;
        repeat (3) @(negedge clk);
        #1 check("R3", 1'b0);
        rst_n = 1'b1;

        // R1: fast tone phase seen through the timer warning on odd seconds
        for (int i = 0; i < 3 * DIV; i++) begin
            @(negedge clk); #1;
            check("R1", fast_at(kcnt));
        end

        // R2: slow tone phase on even seconds
        live_sec = 8'h02;
        for (int i = 0; i < 5 * DIV; i++) begin
            @(negedge clk); #1;
            check("R2", slow_at(kcnt));
        end

        // R3: reset mid-run restarts both tones from their low phase
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1 check("R3", 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 2 * DIV; i++) begin
            @(negedge clk); #1;
            check("R3", slow_at(kcnt));
        end

        // R4/R5/R6/R7/R8/R9/R10 sweep
        for (int a = 0; a < 3; a++) begin
            for (int mi = 0; mi < 3; mi++) begin
                for (int s = 0; s < 60; s++) begin
                    for (int e = 0; e < 2; e++) begin
                        for (int w = 0; w < 2; w++) begin
                            @(negedge clk);
                            case (a)
                                0: begin alarm_hour = 8'h12; alarm_min = 8'h59; end
                                1: begin alarm_hour = 8'h12; alarm_min = 8'h00; end
                                default: begin alarm_hour = 8'h13; alarm_min = 8'h59; end
                            endcase
                            live_hour  = 8'h12;
                            live_min   = (mi == 0) ? 8'h00 : ((mi == 1) ? 8'h58 : 8'h59);
                            live_sec   = {4'(s / 10), 4'(s % 10)};
                            alarm_en_n = logic'(e);
                            timer_warn = logic'(w);
                            for (int t = 0; t < 3; t++) begin
                                if (t != 0) @(negedge clk);
                                #1 check(sweep_tag(), model_buzz(kcnt));
                            end
                        end
                    end
                end
            end
        end
        summary();
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            summary();
        end
    end

endmodule